// File: doc/BRIEF.md
# Software Watchdog With Post-Reset Long Window

This block watches a strobe line that software toggles to prove it is still running. Each rising or falling transition of the strobe restarts a timeout counter that advances on a timebase tick. If the counter reaches the active period before any transition arrives, the block sends a one-cycle timeout request to the system reset generator. It also drives a latched status flag low. The flag stays low until software toggles the strobe again.

After every reset, whatever its cause, the block uses the long period. This gives software time to initialise before it must service the strobe. The normal period replaces the long one only after the first strobe transition that follows reset release. A parameter chooses the timebase variant. With the internal timebase, a period-select pin sets the normal period to short or long. With an external clock, the periods are fixed and the select pin has no effect. The watchdog is idle when the strobe is undriven (strobe-valid low) and when the system runs from the backup battery.

The block has no data path. Every pin is a plain control or status level, or a single-cycle pulse, so no valid/ready handshake is involved.

Top module: `wdt_supervisor`

## Requirements
- R1: A strobe transition in either direction restarts the timeout from zero. With transitions spaced closer than the active period, no timeout request is raised.
- R2: After reset release, the timeout request is raised exactly LONG_TICKS ticks after the release cycle, even when period_sel_long is 0.
- R3: After the first strobe transition that follows release, the active period becomes the normal period: SHORT_TICKS when period_sel_long is 0, LONG_TICKS when it is 1. A timeout is raised that many ticks after the transition.
- R4: While rst_active is 1, the counter is held at zero and no timeout request is raised. Counting resumes from zero at the rst_release pulse.
- R5: If the strobe never moves and each timeout is followed by a reset and release, a timeout request recurs every LONG_TICKS ticks.
- R6: While strobe_valid is 0, the watchdog is disabled: no timeout request, wd_ok held at 1, counter cleared. The first sample after strobe_valid returns to 1 is not taken as a transition.
- R7: On a timeout, wd_ok goes to 0 in the same cycle that timeout_req rises. It stays 0 until the next recognised strobe transition, which sets it back to 1.
- R8: When low_line is 1, wd_ok reads 1 in the following cycle.
- R9: While batt_mode is 1, the strobe is ignored, the counter does not advance, no timeout request is raised, and wd_ok is 1.
- R10: timeout_req is exactly one clock cycle wide. It is raised in the cycle after the tick that completes the period.
- R11: With EXT_CLOCK set, the post-reset period is EXT_LONG_TICKS and the normal period is EXT_NORMAL_TICKS, whatever the value of period_sel_long.
- R12: During rst_n low, and in the first cycle after it, timeout_req is 0 and wd_ok is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low register reset |
| tick | input | 1 | Timebase tick, one cycle per count step |
| strobe_lvl | input | 1 | Synchronised strobe level from software |
| strobe_valid | input | 1 | 1 when the strobe is actively driven; 0 when it is floating or at mid level |
| period_sel_long | input | 1 | Normal period select for the internal timebase: 0 short, 1 long |
| rst_active | input | 1 | System reset currently asserted |
| rst_release | input | 1 | One-cycle pulse marking the end of a system reset |
| low_line | input | 1 | Supply below the reset threshold |
| batt_mode | input | 1 | Output supply switched to the backup battery |
| timeout_req | output | 1 | One-cycle timeout request to the reset generator |
| wd_ok | output | 1 | Latched watchdog status, 0 after a timeout |

## Verification
The hardest state to reach from the ports is the shortened normal period. It needs a reset, a release, exactly one strobe transition, and then silence on a running timebase. This is also the only state where the period-select pin and the external-clock variant show a difference. The bench plays the part of the reset generator: it holds rst_active, pulses rst_release, and toggles the strobe once in the cycle right after release. It then counts cycles to the first request on both an internal-timebase instance and an external-clock instance. Random phases with stuck and busy strobes then drive the emulated reset loop repeatedly against the bench's reference model.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

  typedef enum logic {
    PHASE_NORMAL = 1'b0,
    PHASE_LONG   = 1'b1
  } wdt_phase_e;

  function automatic int wdt_max(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/wdt_edge_detect.sv
module wdt_edge_detect (
  input  logic clk,
  input  logic rst_n,
  input  logic level,
  input  logic valid,
  input  logic enable,
  output logic edge_seen
);
  logic prev_level;
  logic prev_valid;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_level <= 1'b0;
      prev_valid <= 1'b0;
    end else begin
      prev_level <= level;
      prev_valid <= valid;
    end
  end

  // a transition counts only when both samples were driven levels
  assign edge_seen = enable & valid & prev_valid & (level ^ prev_level);

endmodule

// File: rtl/wdt_period_sel.sv
module wdt_period_sel #(
  parameter bit EXT_CLOCK        = 1'b0,
  parameter int SHORT_TICKS      = 1024,
  parameter int LONG_TICKS       = 16384,
  parameter int EXT_NORMAL_TICKS = 1024,
  parameter int EXT_LONG_TICKS   = 4096,
  parameter int CNT_W            = 15
) (
  input  logic             long_phase,
  input  logic             sel_long,
  output logic [CNT_W-1:0] limit
);
  localparam int NORM_LO = EXT_CLOCK ? EXT_NORMAL_TICKS : SHORT_TICKS;
  localparam int NORM_HI = EXT_CLOCK ? EXT_NORMAL_TICKS : LONG_TICKS;
  localparam int POST    = EXT_CLOCK ? EXT_LONG_TICKS   : LONG_TICKS;

  localparam logic [CNT_W-1:0] LIM_LO   = CNT_W'(NORM_LO);
  localparam logic [CNT_W-1:0] LIM_HI   = CNT_W'(NORM_HI);
  localparam logic [CNT_W-1:0] LIM_POST = CNT_W'(POST);

  logic [CNT_W-1:0] normal_lim;

  generate
    if (EXT_CLOCK) begin : g_ext
      assign normal_lim = sel_long ? LIM_HI : LIM_LO;
    end else begin : g_int
      assign normal_lim = sel_long ? LIM_HI : LIM_LO;
    end
  endgenerate

  assign limit = long_phase ? LIM_POST : normal_lim;

endmodule

// File: rtl/wdt_timeout_counter.sv
module wdt_timeout_counter #(
  parameter int CNT_W = 15
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             clear,
  input  logic [CNT_W-1:0] limit,
  output logic             fire,
  output logic             timeout_req
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] last_val;

  assign last_val = limit - CNT_W'(1);
  // >= guards against a period shrinking under a running count
  assign fire     = tick & ~clear & (cnt_q >= last_val);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q       <= '0;
      timeout_req <= 1'b0;
    end else begin
      timeout_req <= fire;
      if (clear || fire) begin
        cnt_q <= '0;
      end else if (tick) begin
        cnt_q <= cnt_q + CNT_W'(1);
      end
    end
  end

endmodule

// File: rtl/wdt_status.sv
module wdt_status (
  input  logic clk,
  input  logic rst_n,
  input  logic force_hi,
  input  logic fire,
  input  logic edge_seen,
  output logic wd_ok
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wd_ok <= 1'b1;
    end else if (force_hi) begin
      wd_ok <= 1'b1;
    end else if (fire) begin
      wd_ok <= 1'b0;
    end else if (edge_seen) begin
      wd_ok <= 1'b1;
    end
  end
endmodule

// File: rtl/wdt_supervisor.sv
module wdt_supervisor
  import wdt_pkg::*;
#(
  parameter bit EXT_CLOCK        = 1'b0,
  parameter int SHORT_TICKS      = 1024,
  parameter int LONG_TICKS       = 16384,
  parameter int EXT_NORMAL_TICKS = 1024,
  parameter int EXT_LONG_TICKS   = 4096
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic strobe_lvl,
  input  logic strobe_valid,
  input  logic period_sel_long,
  input  logic rst_active,
  input  logic rst_release,
  input  logic low_line,
  input  logic batt_mode,
  output logic timeout_req,
  output logic wd_ok
);
  localparam int MAX_TICKS = wdt_max(wdt_max(SHORT_TICKS, LONG_TICKS),
                                     wdt_max(EXT_NORMAL_TICKS, EXT_LONG_TICKS));
  localparam int CNT_W = $clog2(MAX_TICKS + 1);

  logic             run_en;
  logic             edge_seen;
  logic             fire;
  logic             clear;
  logic             long_phase;
  logic [CNT_W-1:0] limit;
  wdt_phase_e       phase_q;

  assign run_en = strobe_valid & ~batt_mode & ~rst_active;

  wdt_edge_detect u_edge (
    .clk       (clk),
    .rst_n     (rst_n),
    .level     (strobe_lvl),
    .valid     (strobe_valid),
    .enable    (run_en),
    .edge_seen (edge_seen)
  );

  // post-reset phase: long window until the first recognised transition
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PHASE_LONG;
    end else if (rst_active || rst_release) begin
      phase_q <= PHASE_LONG;
    end else if (edge_seen) begin
      phase_q <= PHASE_NORMAL;
    end
  end

  assign long_phase = (phase_q == PHASE_LONG);

  wdt_period_sel #(
    .EXT_CLOCK        (EXT_CLOCK),
    .SHORT_TICKS      (SHORT_TICKS),
    .LONG_TICKS       (LONG_TICKS),
    .EXT_NORMAL_TICKS (EXT_NORMAL_TICKS),
    .EXT_LONG_TICKS   (EXT_LONG_TICKS),
    .CNT_W            (CNT_W)
  ) u_psel (
    .long_phase (long_phase),
    .sel_long   (period_sel_long),
    .limit      (limit)
  );

  assign clear = rst_active | rst_release | ~run_en | edge_seen;

  wdt_timeout_counter #(
    .CNT_W (CNT_W)
  ) u_cnt (
    .clk         (clk),
    .rst_n       (rst_n),
    .tick        (tick),
    .clear       (clear),
    .limit       (limit),
    .fire        (fire),
    .timeout_req (timeout_req)
  );

  wdt_status u_stat (
    .clk       (clk),
    .rst_n     (rst_n),
    .force_hi  (low_line | batt_mode | ~strobe_valid),
    .fire      (fire),
    .edge_seen (edge_seen),
    .wd_ok     (wd_ok)
  );

endmodule

// File: rtl/wdt_supervisor_chk.sv
module wdt_supervisor_chk (
  input logic clk,
  input logic rst_n,
  input logic rst_active,
  input logic rst_release,
  input logic strobe_valid,
  input logic low_line,
  input logic batt_mode,
  input logic long_phase,
  input logic timeout_req,
  input logic wd_ok
);
  // R10
  timeout_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    timeout_req |=> !timeout_req);

  // R4
  hold_in_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rst_active |=> !timeout_req);

  // R2
  long_after_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rst_release |=> long_phase);

  // R6
  disabled_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !strobe_valid |=> (wd_ok && !timeout_req));

  // R8
  lowline_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
    low_line |=> wd_ok);

  // R9
  battery_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    batt_mode |=> (wd_ok && !timeout_req));

  // R7
  status_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(wd_ok) |-> timeout_req);
endmodule

bind wdt_supervisor wdt_supervisor_chk u_wdt_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .rst_active   (rst_active),
  .rst_release  (rst_release),
  .strobe_valid (strobe_valid),
  .low_line     (low_line),
  .batt_mode    (batt_mode),
  .long_phase   (long_phase),
  .timeout_req  (timeout_req),
  .wd_ok        (wd_ok)
);

// File: tb/wdt_supervisor_bench.sv
module wdt_supervisor_bench;
  localparam int SH = 6;
  localparam int LG = 25;
  localparam int EN = 5;
  localparam int EL = 12;

  logic clk = 1'b0, rst_n = 1'b0, tick = 1'b0, lvl = 1'b0, vld = 1'b1;
  logic sel = 1'b0, ract = 1'b0, rrel = 1'b0, low = 1'b0, batt = 1'b0;
  logic to_m, ok_m, to_e, ok_e;

  always #10 clk = ~clk;

  wdt_supervisor #(.EXT_CLOCK(1'b0), .SHORT_TICKS(SH), .LONG_TICKS(LG),
                   .EXT_NORMAL_TICKS(EN), .EXT_LONG_TICKS(EL)) u_wdt_supervisor (
    .clk(clk), .rst_n(rst_n), .tick(tick), .strobe_lvl(lvl), .strobe_valid(vld),
    .period_sel_long(sel), .rst_active(ract), .rst_release(rrel), .low_line(low),
    .batt_mode(batt), .timeout_req(to_m), .wd_ok(ok_m));

  wdt_supervisor #(.EXT_CLOCK(1'b1), .SHORT_TICKS(SH), .LONG_TICKS(LG),
                   .EXT_NORMAL_TICKS(EN), .EXT_LONG_TICKS(EL)) u_wdt_supervisor_ext (
    .clk(clk), .rst_n(rst_n), .tick(tick), .strobe_lvl(lvl), .strobe_valid(vld),
    .period_sel_long(sel), .rst_active(ract), .rst_release(rrel), .low_line(low),
    .batt_mode(batt), .timeout_req(to_e), .wd_ok(ok_e));

  int checks = 0, fails = 0, cyc_n = 0;
  string req = "R12";

  // reference model built from the requirements
  int m_cnt = 0;
  bit m_long = 1, m_pl = 0, m_pv = 0, m_to = 0, m_ok = 1;
  bit en_m, ed_m, fire_m;
  int lim_m;

  function automatic int period(input bit lp, input bit s);
    return lp ? LG : (s ? LG : SH);
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_cnt = 0; m_long = 1; m_pl = 0; m_pv = 0; m_to = 0; m_ok = 1;
    end else begin
      en_m   = vld && !batt && !ract;
      ed_m   = en_m && m_pv && (lvl != m_pl);
      lim_m  = period(m_long, sel);
      fire_m = en_m && !ed_m && !rrel && tick && (m_cnt >= lim_m - 1);
      m_to   = fire_m;
      if (ract || rrel || !en_m || ed_m || fire_m) m_cnt = 0;
      else if (tick) m_cnt = m_cnt + 1;
      if (ract || rrel) m_long = 1;
      else if (ed_m) m_long = 0;
      if (low || batt || !vld) m_ok = 1;
      else if (fire_m) m_ok = 0;
      else if (ed_m) m_ok = 1;
      m_pl = lvl; m_pv = vld;
    end
  end

  function automatic void summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
  endfunction

  always @(posedge clk) begin
    cyc_n++;
    if (cyc_n > 150000) begin
      fails++;
      $display("FAIL watchdog expired actual=%0d expected<=150000", cyc_n);
      summary();
      $finish;
    end
  end

  task automatic check(input string r, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", r, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    @(negedge clk);
    check({req, " timeout_req vs model"}, int'(to_m), int'(m_to));
    check({req, " wd_ok vs model"}, int'(ok_m), int'(m_ok));
  endtask

  task automatic do_reset(input int n);
    ract = 1'b1;
    repeat (n) cyc();
    ract = 1'b0; rrel = 1'b1;
    cyc();
    rrel = 1'b0;
  endtask

  // cycles from restart to first request on both instances
  task automatic measure(input bit s, input bit edge_first, output int tm,
                         output int te, output int wide);
    sel = s; tick = 1'b1;
    do_reset(3);
    if (edge_first) begin
      lvl = ~lvl;
      cyc();
    end
    tm = -1; te = -1; wide = 0;
    for (int i = 1; i <= 40; i++) begin
      cyc();
      if (to_m && tm < 0) tm = i;
      if (to_e && te < 0) te = i;
      if (to_m && i == tm + 1) wide = 1;
    end
    tick = 1'b0;
  endtask

  int tm, te, wide, hits, rg;
  bit pend;

  initial begin
    void'($urandom(32'h5EED_2024));
    repeat (3) @(negedge clk);
    // R12 reset state
    check("R12 timeout_req in reset", int'(to_m), 0);
    check("R12 wd_ok in reset", int'(ok_m), 1);
    rst_n = 1'b1;
    cyc();
    check("R12 timeout_req after reset", int'(to_m), 0);
    check("R12 wd_ok after reset", int'(ok_m), 1);

    req = "R2";
    measure(1'b0, 1'b0, tm, te, wide);
    check("R2 post-release period with short select", tm, LG);
    check("R10 pulse width one cycle", wide, 0);
    check("R11 external post-reset period", te, EL);

    req = "R3";
    measure(1'b0, 1'b1, tm, te, wide);
    check("R3 short normal period after first edge", tm, SH);
    check("R11 external normal period", te, EN);
    measure(1'b1, 1'b1, tm, te, wide);
    check("R3 long normal period with select high", tm, LG);
    check("R11 select ignored in external mode", te, EN);

    req = "R5";
    for (int k = 0; k < 3; k++) begin
      measure(1'b0, 1'b0, tm, te, wide);
      check("R5 repeated long timeout", tm, LG);
    end

    req = "R7";
    sel = 1'b0; tick = 1'b1;
    do_reset(2);
    lvl = ~lvl; cyc();
    repeat (SH) cyc();
    check("R7 timeout raised", int'(to_m), 1);
    check("R7 status low with timeout", int'(ok_m), 0);
    tick = 1'b0;
    for (int i = 0; i < 8; i++) begin
      cyc();
      check("R7 status stays low", int'(ok_m), 0);
    end
    lvl = ~lvl; cyc();
    check("R7 status high after edge", int'(ok_m), 1);
    tick = 1'b1;
    repeat (SH) cyc();
    check("R7 second timeout low", int'(ok_m), 0);
    req = "R8";
    low = 1'b1; cyc(); low = 1'b0;
    check("R8 low_line forces status high", int'(ok_m), 1);

    req = "R1";
    do_reset(2);
    hits = 0;
    for (int k = 0; k < 12; k++) begin
      lvl = ~lvl; cyc();
      if (to_m) hits++;
      for (int j = 0; j < SH - 2; j++) begin
        cyc();
        if (to_m) hits++;
      end
    end
    check("R1 both edge directions keep timer quiet", hits, 0);

    req = "R6";
    vld = 1'b0; hits = 0;
    for (int i = 0; i < 3 * LG; i++) begin
      if (i % 4 == 0) lvl = ~lvl;
      cyc();
      if (to_m || !ok_m) hits++;
    end
    vld = 1'b1; lvl = ~lvl; cyc();
    check("R6 invalid strobe: no timeout, status high", hits, 0);
    check("R6 no phantom edge on return to valid", int'(to_m), 0);

    req = "R9";
    batt = 1'b1; hits = 0;
    for (int i = 0; i < 3 * LG; i++) begin
      if (i % 3 == 0) lvl = ~lvl;
      cyc();
      if (to_m || !ok_m) hits++;
    end
    batt = 1'b0;
    check("R9 battery mode: strobe ignored, no timeout", hits, 0);

    req = "R4";
    ract = 1'b1; hits = 0;
    for (int i = 0; i < 3 * LG; i++) begin
      cyc();
      if (to_m) hits++;
    end
    check("R4 no timeout while reset held", hits, 0);
    measure(1'b0, 1'b0, tm, te, wide);
    check("R4 count restarts from zero at release", tm, LG);

    // random phases with an emulated reset generator
    req = "RND";
    rg = 0; pend = 0;
    for (int p = 0; p < 24; p++) begin
      int tog_p;
      sel = 1'($urandom % 2);
      tog_p = (p % 3 == 0) ? 0 : int'($urandom % 4) + 1;
      for (int c = 0; c < 150; c++) begin
        tick = 1'($urandom % 2);
        if (tog_p != 0 && int'($urandom % 16) < tog_p) lvl = ~lvl;
        vld  = (($urandom % 40) != 0);
        low  = (($urandom % 50) == 0);
        batt = (($urandom % 80) == 0);
        if (rg > 0) begin
          ract = 1'b1; rrel = 1'b0; rg--;
          if (rg == 0) pend = 1;
        end else if (pend) begin
          ract = 1'b0; rrel = 1'b1; pend = 0;
        end else begin
          ract = 1'b0; rrel = 1'b0;
          if (to_m) rg = 2 + int'($urandom % 3);
          else if (($urandom % 100) == 0) rg = 2;
        end
        cyc();
      end
    end
    summary();
    $finish;
  end
endmodule